// File: doc/BRIEF.md
# Dual-Output Compare Waveform Timer

This block is one timer channel running in waveform mode. A single up-counter runs from zero up to a shared period value and then restarts at zero. Two outputs, A and B, each have their own duty compare value. Each output drives its level from a small table of actions. The table says what to do with the output on four kinds of event: the output's own duty compare, the period compare, a rising edge on the external event input, and a software trigger. For each event the action is to leave the output alone, set it, clear it or toggle it. Because the outputs follow these actions and not a fixed compare rule, a 0% or 100% waveform is made by giving both compare actions "none". The output then keeps whatever level the software trigger gave it.

Configuration comes through a small write port: a mode word, the two duty values and the period value. Each write takes effect on the next cycle. A command port starts the counter, halts it, or restarts it with a software trigger. The trigger can be combined with a start or with a halt. The counter does not run on its own clock. It advances on a one-cycle tick enable, taken either from a free-running divider of the main clock or from rising edges of a synchronized slow clock input. The whole block therefore stays in one clock domain.

Control is held in a two-state machine. The state HALT means the counter is frozen. The state RUN means the counter advances on each tick. The transition START (HALT to RUN) happens on a command with the start bit set and the halt bit clear. The transition STOP (RUN to HALT) happens on any command with the halt bit set.

Top module: `dualcmp_wave_timer`

## Requirements
- R1: The counter runs in the RUN state. On each tick it either increments or, when its value equals the period value, returns to zero on that same tick. One period is therefore period+1 ticks, and the counter never passes the period value once it has wrapped.
- R2: With the duty action set to clear and the period action set to set (normal polarity), an output is high for duty+1 ticks and low for period-duty ticks in every period.
- R3: With the duty action set to set and the period action set to clear (inverted polarity), an output is high for period-duty ticks and low for duty+1 ticks.
- R4: Within one output, a software trigger outranks an external event, which outranks the period compare, which outranks the duty compare. So when duty equals period under normal polarity, the output stays high.
- R5: A software trigger command sets the counter to zero on the next cycle and applies each output's trigger action at once. Action codes: 0 none, 1 set, 2 clear, 3 toggle. Mode word layout: bits 2:0 clock select; for output A, duty action 4:3, period action 6:5, external action 8:7, trigger action 10:9; for output B the same four fields at 12:11, 14:13, 16:15, 18:17.
- R6: A command with the halt bit set moves the state machine to HALT. In HALT the counter value and both outputs hold their levels. Halt wins when start and halt arrive in the same command. A trigger combined with a halt zeroes the counter and leaves it halted.
- R7: The clock select codes 0, 1, 2 and 3 give one tick every 2, 8, 32 and 128 main clocks. Codes 4 to 7 give one tick per rising edge of the slow clock input.
- R8: When both compare actions of an output are none, the output keeps the level set by its trigger action for as long as it runs (the 0% and 100% cases).
- R9: In RUN, a rising edge on the external event input applies the external action once. A held-high input does not repeat the action, and an edge in HALT does nothing.
- R10: The toggle action inverts the output. A toggle on the period compare alone gives a square wave with a half-period of period+1 ticks.
- R11: After reset both outputs are low, the counter is zero, the state is HALT, the mode word is zero, and the duty and period values are zero.
- R12: Write address 0 loads the mode word, 1 the output A duty, 2 the output B duty, and 3 the period. Output B follows its own duty value independently of A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_clk_in | input | 1 | Asynchronous slow clock used as a tick source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | BUS_W | Configuration write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_start | input | 1 | Command bit: start counting |
| cmd_stop | input | 1 | Command bit: halt counting |
| cmd_trig | input | 1 | Command bit: software trigger |
| ext_evt | input | 1 | External event input (rising edge acts) |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |
| count | output | CNT_W | Current counter value |

## Verification
The bench sweeps every duty value below the period for two small periods, under both polarities, and measures the high and low stretch of each output in main clocks. A design with an off-by-one in the compare or the wrap would be a tick long or short on every case, and a design that mixed up the A and B duty values would fail the B sweep. Duty equal to the period is checked to stay high, which catches a duty compare that outranks the period compare. Every divider setting and the slow clock are measured, along with a halt that must freeze both the count and the levels, and halt-and-start in one command. The bench also checks that an external input held high acts only once, and that a trigger with all compare actions none leaves a truly static level.

// File: rtl/wt_pkg.sv
package wt_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_TGL  = 2'd3
    } act_e;

    // Per-output action table: duty in the low bits, trigger in the high bits.
    typedef struct packed {
        act_e sw;
        act_e ext;
        act_e per;
        act_e duty;
    } out_acts_t;

    typedef struct packed {
        out_acts_t  b;
        out_acts_t  a;
        logic [2:0] clksel;
    } mode_t;

    localparam int MODE_W  = $bits(mode_t);
    localparam int N_OUT   = 2;
    localparam int PRE_W   = 7;   // enough for the largest divider, 128

    localparam logic [1:0] ADDR_MODE = 2'd0;
    localparam logic [1:0] ADDR_DA   = 2'd1;
    localparam logic [1:0] ADDR_DB   = 2'd2;
    localparam logic [1:0] ADDR_PER  = 2'd3;

endpackage

// File: rtl/wt_tick_gen.sv
module wt_tick_gen
    import wt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slow_in,
    input  logic [2:0] sel,
    output logic       tick
);

    logic [PRE_W-1:0] pre_q;
    logic [2:0]       slow_sync_q;
    logic             slow_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q       <= '0;
            slow_sync_q <= '0;
        end else begin
            pre_q       <= pre_q + 1'b1;
            slow_sync_q <= {slow_sync_q[1:0], slow_in};
        end
    end

    assign slow_rise = slow_sync_q[1] & ~slow_sync_q[2];

    always_comb begin
        unique case (sel)
            3'd0:    tick = pre_q[0];
            3'd1:    tick = &pre_q[2:0];
            3'd2:    tick = &pre_q[4:0];
            3'd3:    tick = &pre_q[6:0];
            default: tick = slow_rise;
        endcase
    end

endmodule

// File: rtl/wt_counter.sv
module wt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cmd_valid,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    input  logic             cmd_trig,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic             trig,
    output logic             step,
    output logic             per_hit
);

    typedef enum logic {ST_HALT, ST_RUN} st_e;

    st_e st_q, st_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HALT;
        else        st_q <= st_d;
    end

    // Transitions START and STOP
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HALT: if (cmd_valid && cmd_start && !cmd_stop) st_d = ST_RUN;
            ST_RUN:  if (cmd_valid && cmd_stop)               st_d = ST_HALT;
        endcase
    end

    // State-derived outputs
    always_comb begin
        run     = (st_q == ST_RUN);
        trig    = cmd_valid && cmd_trig;
        step    = run && tick && !trig;
        per_hit = step && (cnt == period);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (trig)    cnt <= '0;
        else if (per_hit) cnt <= '0;
        else if (step)    cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/wt_out_ctl.sv
module wt_out_ctl
    import wt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  out_acts_t acts,
    input  logic      trig,
    input  logic      ext_hit,
    input  logic      per_hit,
    input  logic      duty_hit,
    output logic      wave
);

    act_e act;

    always_comb begin
        if (trig)          act = acts.sw;
        else if (ext_hit)  act = acts.ext;
        else if (per_hit)  act = acts.per;
        else if (duty_hit) act = acts.duty;
        else               act = ACT_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wave <= 1'b0;
        end else begin
            unique case (act)
                ACT_NONE: wave <= wave;
                ACT_SET:  wave <= 1'b1;
                ACT_CLR:  wave <= 1'b0;
                ACT_TGL:  wave <= ~wave;
            endcase
        end
    end

endmodule

// File: rtl/dualcmp_wave_timer.sv
module dualcmp_wave_timer
    import wt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_clk_in,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [BUS_W-1:0] cfg_wdata,
    input  logic             cmd_valid,
    input  logic             cmd_start,
    input  logic             cmd_stop,
    input  logic             cmd_trig,
    input  logic             ext_evt,
    output logic             out_a,
    output logic             out_b,
    output logic [CNT_W-1:0] count
);

    mode_t            mode_q;
    logic [CNT_W-1:0] duty_q [N_OUT];
    logic [CNT_W-1:0] rc_q;
    logic             ext_q;
    logic             tick, run, trig, step, per_hit, ext_hit;
    logic [N_OUT-1:0] waves;
    out_acts_t        acts [N_OUT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= '0;
            duty_q[0] <= '0;
            duty_q[1] <= '0;
            rc_q      <= '0;
            ext_q     <= 1'b0;
        end else begin
            ext_q <= ext_evt;
            if (cfg_we) begin
                unique case (cfg_addr)
                    ADDR_MODE: mode_q    <= mode_t'(cfg_wdata[MODE_W-1:0]);
                    ADDR_DA:   duty_q[0] <= cfg_wdata[CNT_W-1:0];
                    ADDR_DB:   duty_q[1] <= cfg_wdata[CNT_W-1:0];
                    ADDR_PER:  rc_q      <= cfg_wdata[CNT_W-1:0];
                endcase
            end
        end
    end

    assign ext_hit = run && ext_evt && !ext_q && !trig;
    assign acts[0] = mode_q.a;
    assign acts[1] = mode_q.b;

    wt_tick_gen u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .slow_in (slow_clk_in),
        .sel     (mode_q.clksel),
        .tick    (tick)
    );

    wt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cmd_valid (cmd_valid),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .cmd_trig  (cmd_trig),
        .period    (rc_q),
        .cnt       (count),
        .run       (run),
        .trig      (trig),
        .step      (step),
        .per_hit   (per_hit)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        logic duty_hit;
        assign duty_hit = step && (count == duty_q[g]);

        wt_out_ctl u_out (
            .clk      (clk),
            .rst_n    (rst_n),
            .acts     (acts[g]),
            .trig     (trig),
            .ext_hit  (ext_hit),
            .per_hit  (per_hit),
            .duty_hit (duty_hit),
            .wave     (waves[g])
        );
    end

    assign out_a = waves[0];
    assign out_b = waves[1];

endmodule

// File: rtl/dualcmp_wave_timer_chk.sv
module dualcmp_wave_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             run,
    input logic             trig,
    input logic             ext_hit,
    input logic             cfg_we,
    input logic             cmd_valid,
    input logic             cmd_stop,
    input logic [2:0]       clksel,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] rc,
    input logic             out_a,
    input logic             out_b
);

    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !trig && cnt == rc) |=> (cnt == '0));

    p_trig_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (cnt == '0));

    p_halt_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !trig) |=> $stable(cnt));

    p_stop_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_stop) |=> !run);

    p_hold_between_events_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !trig && !ext_hit) |=> ($stable(out_a) && $stable(out_b)));

    p_div2_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && clksel == 3'd0 && !cfg_we) |=> !tick);

endmodule

bind dualcmp_wave_timer dualcmp_wave_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .run       (run),
    .trig      (trig),
    .ext_hit   (ext_hit),
    .cfg_we    (cfg_we),
    .cmd_valid (cmd_valid),
    .cmd_stop  (cmd_stop),
    .clksel    (mode_q.clksel),
    .cnt       (count),
    .rc        (rc_q),
    .out_a     (out_a),
    .out_b     (out_b)
);

// File: tb/dualcmp_wave_timer_tb.sv
module dualcmp_wave_timer_tb;

    localparam int CNT_W = 16;
    localparam int BUS_W = 32;
    localparam int CAP   = 4000;

    localparam int NONE = 0, SET = 1, CLR = 2, TGL = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             slow_clk_in = 1'b0;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_addr = '0;
    logic [BUS_W-1:0] cfg_wdata = '0;
    logic             cmd_valid = 1'b0;
    logic             cmd_start = 1'b0;
    logic             cmd_stop = 1'b0;
    logic             cmd_trig = 1'b0;
    logic             ext_evt = 1'b0;
    logic             out_a, out_b;
    logic [CNT_W-1:0] count;

    int n_checks = 0;
    int n_errors = 0;

    dualcmp_wave_timer #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_clk_in (slow_clk_in),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .cmd_valid   (cmd_valid),
        .cmd_start   (cmd_start),
        .cmd_stop    (cmd_stop),
        .cmd_trig    (cmd_trig),
        .ext_evt     (ext_evt),
        .out_a       (out_a),
        .out_b       (out_b),
        .count       (count)
    );

    always #4 clk = ~clk;

    initial begin
        #4;
        forever #80 slow_clk_in = ~slow_clk_in;
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual timeout expected completion");
        summary();
    end

    function automatic logic [BUS_W-1:0] mk_mode(
        input int sel,
        input int ad, input int ap, input int ae, input int as,
        input int bd, input int bp, input int be, input int bs);
        logic [BUS_W-1:0] m;
        m = '0;
        m[2:0]   = sel[2:0];
        m[4:3]   = ad[1:0];
        m[6:5]   = ap[1:0];
        m[8:7]   = ae[1:0];
        m[10:9]  = as[1:0];
        m[12:11] = bd[1:0];
        m[14:13] = bp[1:0];
        m[16:15] = be[1:0];
        m[18:17] = bs[1:0];
        return m;
    endfunction

    task automatic wr(input int addr, input logic [BUS_W-1:0] data);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = addr[1:0]; cfg_wdata = data;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic cmd(input logic st, input logic sp, input logic tr);
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_start = st; cmd_stop = sp; cmd_trig = tr;
        @(posedge clk); #1;
        cmd_valid = 1'b0; cmd_start = 1'b0; cmd_stop = 1'b0; cmd_trig = 1'b0;
    endtask

    function automatic logic pick(input int w);
        return (w == 0) ? out_a : out_b;
    endfunction

    task automatic run_len(input int w, output int n);
        logic v;
        v = pick(w);
        n = 0;
        while (pick(w) == v && n < CAP) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic measure(input int w, output int hi, output int lo);
        int d;
        @(negedge clk);
        run_len(w, d);
        run_len(w, d);
        if (pick(w)) begin
            run_len(w, hi);
            run_len(w, lo);
        end else begin
            run_len(w, lo);
            run_len(w, hi);
        end
    endtask

    task automatic setup(input logic [BUS_W-1:0] m, input int da, input int db, input int per);
        wr(0, m);
        wr(1, da);
        wr(2, db);
        wr(3, per);
        cmd(1'b1, 1'b0, 1'b1);
    endtask

    task automatic hold_check(input string req, input int w, input int exp, input int cycles);
        int bad;
        bad = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pick(w) != exp[0]) bad++;
        end
        check(req, bad, 0);
    endtask

    initial begin
        int hi, lo, c0, a0, b0;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11: reset state, halted counter
        @(negedge clk);
        check("R11 out_a after reset", out_a, 0);
        check("R11 out_b after reset", out_b, 0);
        check("R11 count after reset", count, 0);
        repeat (10) @(negedge clk);
        check("R11 counter halted after reset", count, 0);

        // R2 / R12 / R1: sweep normal polarity, periods 3 and 4, divider 2
        for (int per = 3; per <= 4; per++) begin
            for (int d = 0; d < per; d++) begin
                int db;
                db = per - 1 - d;
                setup(mk_mode(0, CLR, SET, NONE, SET, CLR, SET, NONE, SET), d, db, per);
                measure(0, hi, lo);
                check($sformatf("R2 A high per=%0d duty=%0d", per, d), hi, 2 * (d + 1));
                check($sformatf("R2 A low per=%0d duty=%0d", per, d), lo, 2 * (per - d));
                check($sformatf("R1 A period per=%0d", per), hi + lo, 2 * (per + 1));
                measure(1, hi, lo);
                check($sformatf("R12 B high per=%0d duty=%0d", per, db), hi, 2 * (db + 1));
                check($sformatf("R12 B low per=%0d duty=%0d", per, db), lo, 2 * (per - db));
            end
        end

        // R3: inverted polarity sweep, period 3
        for (int d = 0; d < 3; d++) begin
            setup(mk_mode(0, SET, CLR, NONE, CLR, SET, CLR, NONE, CLR), d, d, 3);
            measure(0, hi, lo);
            check($sformatf("R3 A high inverted duty=%0d", d), hi, 2 * (3 - d));
            check($sformatf("R3 A low inverted duty=%0d", d), lo, 2 * (d + 1));
        end

        // R4: duty equal to period, period action wins, output stays high
        setup(mk_mode(0, CLR, SET, NONE, SET, CLR, SET, NONE, SET), 3, 1, 3);
        hold_check("R4 duty==period stays high", 0, 1, 60);

        // R10: toggle on period only gives a square wave
        setup(mk_mode(0, NONE, TGL, NONE, CLR, CLR, SET, NONE, SET), 1, 1, 3);
        measure(0, hi, lo);
        check("R10 toggle high", hi, 8);
        check("R10 toggle low", lo, 8);

        // R7: dividers 8, 32, 128 and slow clock
        setup(mk_mode(1, CLR, SET, NONE, SET, CLR, SET, NONE, SET), 1, 1, 3);
        measure(0, hi, lo);
        check("R7 div8 high", hi, 16);
        check("R7 div8 low", lo, 16);
        setup(mk_mode(2, CLR, SET, NONE, SET, CLR, SET, NONE, SET), 0, 0, 1);
        measure(0, hi, lo);
        check("R7 div32 high", hi, 32);
        check("R7 div32 low", lo, 32);
        setup(mk_mode(3, CLR, SET, NONE, SET, CLR, SET, NONE, SET), 0, 0, 1);
        measure(0, hi, lo);
        check("R7 div128 high", hi, 128);
        check("R7 div128 low", lo, 128);
        setup(mk_mode(4, CLR, SET, NONE, SET, CLR, SET, NONE, SET), 0, 0, 2);
        measure(0, hi, lo);
        check("R7 slow clock high", hi, 20);
        check("R7 slow clock low", lo, 40);

        // R6: halt freezes counter and outputs
        setup(mk_mode(0, CLR, SET, NONE, SET, CLR, SET, NONE, SET), 5, 2, 11);
        repeat (7) @(negedge clk);
        cmd(1'b0, 1'b1, 1'b0);
        @(negedge clk);
        c0 = count; a0 = out_a; b0 = out_b;
        repeat (30) @(negedge clk);
        check("R6 count frozen in halt", count, c0);
        check("R6 out_a held in halt", out_a, a0);
        check("R6 out_b held in halt", out_b, b0);
        // start and halt together: halt wins
        cmd(1'b1, 1'b1, 1'b0);
        repeat (20) @(negedge clk);
        check("R6 start+halt stays halted", count, c0);
        // trigger with halt: zero and halted
        cmd(1'b0, 1'b1, 1'b1);
        repeat (20) @(negedge clk);
        check("R6 trigger+halt zeroes and halts", count, 0);
        check("R6 trigger+halt applies set on A", out_a, 1);

        // R5: trigger alone while running zeroes counter next cycle
        setup(mk_mode(0, NONE, NONE, NONE, TGL, CLR, SET, NONE, SET), 0, 0, 200);
        repeat (40) @(negedge clk);
        a0 = out_a;
        cmd(1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check("R5 trigger zeroes counter", count, 0);
        check("R5 trigger toggles A", out_a, ~a0 & 1);
        cmd(1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check("R5 second trigger toggles A back", out_a, a0);

        // R8: static 0% and 100% with compare actions none
        setup(mk_mode(0, NONE, NONE, NONE, CLR, NONE, NONE, NONE, SET), 1, 1, 3);
        hold_check("R8 A static low", 0, 0, 50);
        hold_check("R8 B static high", 1, 1, 10);

        // R9: external edge acts once while running, not in halt
        setup(mk_mode(0, NONE, NONE, TGL, CLR, NONE, NONE, NONE, CLR), 1, 1, 3);
        @(negedge clk);
        check("R9 A cleared before event", out_a, 0);
        @(posedge clk); #1 ext_evt = 1'b1;
        repeat (6) @(posedge clk);
        #1 ext_evt = 1'b0;
        @(negedge clk);
        check("R9 held event toggles once", out_a, 1);
        cmd(1'b0, 1'b1, 1'b0);
        @(posedge clk); #1 ext_evt = 1'b1;
        repeat (3) @(posedge clk);
        #1 ext_evt = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 event ignored in halt", out_a, 1);

        summary();
    end

endmodule